// File: doc/BRIEF.md
# Pointer-Register Load/Store Unit

This unit executes 32-bit loads and stores for a multithreaded core whose addresses have already been translated. Each thread owns four hidden base registers, one for each of the architectural pointer registers 12, 13, 14 and 15. An operation names a thread, a pointer index, a 12-bit offset, store data and, for loads, a destination register. The physical address is formed by ORing the hidden base with the zero-extended offset. No adder is involved, so the offset acts as a field inside a naturally aligned block.

Each accepted, aligned operation takes one of four transaction buffers. The buffer drives a request on the external bus and waits for that request's response. It is released only when the transaction commits. A completed load must also win a writeback slot toward its own thread's register file before it leaves. Buffers leave in the order they were allocated.

Two streams have back-pressure. The operation input is valid/ready: a source holds `op_valid` and its fields until `op_ready` is seen high at a clock edge. The bus request is valid/ready: the unit holds the request until `bus_req_ready`. Responses, hidden-register writes, invalidation, error reports and writebacks are plain pulses without back-pressure.

Top module: `ptr_lsu`

## Requirements
- R1: After reset, `op_ready` is 1, `bus_req_valid`, `wb_valid` and `err_valid` are 0, and every hidden base register of every thread is zero.
- R2: The request address is `base[op_thread][op_ptr] | {20'b0, op_ofs}`. Pointer index k (2 bits) selects the hidden register of pointer register 12+k. For stores, `bus_req_we` is 1, and it is 0 for loads.
- R3: A hidden-register write (`base_we`) takes effect at the clock edge. An operation accepted in the same cycle uses the previous base value.
- R4: `inval` clears all four hidden registers of `inval_thread` at the edge. It wins over a `base_we` aimed at the same thread in that cycle.
- R5: An accepted operation whose formed address has bits [1:0] not equal to 00 takes no buffer and never reaches the bus. `err_valid` pulses for one cycle, in the cycle after acceptance, with `err_thread` set to the operation's thread.
- R6: An operation is accepted on a cycle with `op_valid` and `op_ready` both high. `op_ready` is low exactly when all four buffers are occupied, judged by the occupancy before any release in that cycle.
- R7: Requests appear on the bus in allocation order, at the earliest one cycle after acceptance. While `bus_req_ready` is low, `bus_req_valid`, `bus_req_addr`, `bus_req_we` and `bus_req_wdata` hold steady.
- R8: Each `bus_rsp_valid` completes the oldest issued transaction that has no response yet. `bus_rsp_rdata` is captured for a load. A completed store's buffer is released at the first edge where it is the oldest buffer.
- R9: `wb_valid` is high when the oldest buffer is a completed load and `wb_slot_free[thread]` is high. In that cycle `wb_thread`, `wb_reg` and `wb_data` give the owning thread, the destination register and the loaded data. The buffer is released at that edge. Younger completed buffers wait behind the oldest one.
- R10: For a store, `bus_req_wdata` equals the `op_wdata` presented at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Operation can be accepted |
| op_thread | input | 2 | Owning thread |
| op_store | input | 1 | 1 for store, 0 for load |
| op_ptr | input | 2 | Pointer index k, selecting register 12+k |
| op_ofs | input | 12 | OR offset (operand B) |
| op_wdata | input | 32 | Store data (operand A) |
| op_dest | input | 4 | Load destination register |
| base_we | input | 1 | Write a hidden base register |
| base_thread | input | 2 | Thread of the hidden-register write |
| base_ptr | input | 2 | Pointer index of the hidden-register write |
| base_addr | input | 32 | Translated base value |
| inval | input | 1 | Clear one thread's hidden registers |
| inval_thread | input | 2 | Thread to clear |
| err_valid | output | 1 | Misaligned operation was dropped |
| err_thread | output | 2 | Thread of the dropped operation |
| bus_req_valid | output | 1 | Bus request valid |
| bus_req_ready | input | 1 | Bus accepts request |
| bus_req_addr | output | 32 | Physical address |
| bus_req_we | output | 1 | Write request |
| bus_req_wdata | output | 32 | Write data |
| bus_rsp_valid | input | 1 | Oldest outstanding request committed |
| bus_rsp_rdata | input | 32 | Read data |
| wb_slot_free | input | 4 | Per-thread free writeback slot |
| wb_valid | output | 1 | Load result written back |
| wb_thread | output | 2 | Writeback thread |
| wb_reg | output | 4 | Writeback destination register |
| wb_data | output | 32 | Writeback data |

## Verification
Two pairs of functions can fall in the same cycle and are exercised on purpose.

The first pair is address formation and hidden-register maintenance. An operation is accepted in the cycle that rewrites its own base, and an invalidate coincides with a base write to the same thread. The test is which base value the later bus address reveals.

The second pair is allocation and release. A full unit sees a writeback or a store commit while a new operation waits. The reference model requires that `op_ready` stays low for that cycle and that the freed buffer is taken one cycle later.

Both pairs also occur in long randomized runs with varying bus, response and slot rates. A behavioural queue model compares every output on every clock.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic {
    ACC_LOAD  = 1'b0,
    ACC_STORE = 1'b1
  } acc_kind_e;
endpackage

// File: rtl/lsu_base_regs.sv
module lsu_base_regs #(
  parameter int NT = 4,
  parameter int NP = 4,
  parameter int AW = 32,
  localparam int TW = $clog2(NT),
  localparam int PW = $clog2(NP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [TW-1:0] wthread,
  input  logic [PW-1:0] wptr,
  input  logic [AW-1:0] wdata,
  input  logic          inval,
  input  logic [TW-1:0] inval_thread,
  input  logic [TW-1:0] rthread,
  input  logic [PW-1:0] rptr,
  output logic [AW-1:0] rdata
);
  logic [AW-1:0] base_q [NT][NP];

  always_ff @(posedge clk) begin
    for (int t = 0; t < NT; t++) begin
      for (int p = 0; p < NP; p++) begin
        if (!rst_n) begin
          base_q[t][p] <= '0;
        end else if (inval && inval_thread == TW'(t)) begin
          base_q[t][p] <= '0;
        end else if (we && wthread == TW'(t) && wptr == PW'(p)) begin
          base_q[t][p] <= wdata;
        end
      end
    end
  end

  assign rdata = base_q[rthread][rptr];

  // R4
  inval_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inval |=> base_q[$past(inval_thread)][0] == '0);
endmodule

// File: rtl/lsu_txn_ring.sv
module lsu_txn_ring
  import lsu_pkg::*;
#(
  parameter int NB = 4,
  parameter int NT = 4,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int RW = 4,
  localparam int TW = $clog2(NT),
  localparam int IW = $clog2(NB),
  localparam int CW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc,
  input  acc_kind_e     alloc_kind,
  input  logic [TW-1:0] alloc_thread,
  input  logic [RW-1:0] alloc_reg,
  input  logic [AW-1:0] alloc_addr,
  input  logic [DW-1:0] alloc_wdata,
  output logic          full,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  output logic          req_we,
  output logic [DW-1:0] req_wdata,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_rdata,
  input  logic [NT-1:0] slot_free,
  output logic          wb_valid,
  output logic [TW-1:0] wb_thread,
  output logic [RW-1:0] wb_reg,
  output logic [DW-1:0] wb_data
);
  acc_kind_e     kind_q [NB];
  logic [TW-1:0] thr_q  [NB];
  logic [RW-1:0] reg_q  [NB];
  logic [AW-1:0] addr_q [NB];
  logic [DW-1:0] data_q [NB];
  logic [NB-1:0] done_q;

  logic [CW-1:0] head_q, iss_q, rsp_q, tail_q, count;
  logic [IW-1:0] head_i, iss_i, rsp_i, tail_i;
  logic          rsp_pend, head_done, head_st, release_w, take_rsp;

  assign head_i = head_q[IW-1:0];
  assign iss_i  = iss_q[IW-1:0];
  assign rsp_i  = rsp_q[IW-1:0];
  assign tail_i = tail_q[IW-1:0];

  assign count     = tail_q - head_q;
  assign full      = count == CW'(NB);
  assign req_valid = iss_q != tail_q;
  assign rsp_pend  = rsp_q != iss_q;
  assign take_rsp  = rsp_valid && rsp_pend;
  assign head_done = (head_q != tail_q) && done_q[head_i];
  assign head_st   = kind_q[head_i] == ACC_STORE;
  assign wb_valid  = head_done && !head_st && slot_free[thr_q[head_i]];
  assign release_w = head_done && (head_st || slot_free[thr_q[head_i]]);

  assign req_addr  = addr_q[iss_i];
  assign req_we    = kind_q[iss_i] == ACC_STORE;
  assign req_wdata = data_q[iss_i];
  assign wb_thread = thr_q[head_i];
  assign wb_reg    = reg_q[head_i];
  assign wb_data   = data_q[head_i];

  always_ff @(posedge clk) begin
    if (alloc) begin
      kind_q[tail_i] <= alloc_kind;
      thr_q[tail_i]  <= alloc_thread;
      reg_q[tail_i]  <= alloc_reg;
      addr_q[tail_i] <= alloc_addr;
      data_q[tail_i] <= alloc_wdata;
    end
    if (take_rsp && kind_q[rsp_i] == ACC_LOAD) begin
      data_q[rsp_i] <= rsp_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= '0;
      head_q <= '0;
      iss_q  <= '0;
      rsp_q  <= '0;
      tail_q <= '0;
    end else begin
      if (alloc) begin
        done_q[tail_i] <= 1'b0;
        tail_q <= tail_q + 1'b1;
      end
      if (take_rsp) begin
        done_q[rsp_i] <= 1'b1;
        rsp_q <= rsp_q + 1'b1;
      end
      if (req_valid && req_ready) iss_q <= iss_q + 1'b1;
      if (release_w) head_q <= head_q + 1'b1;
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(NB));
  // R6
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !alloc);
  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) &&
      $stable(req_we) && $stable(req_wdata));
  // R9
  wb_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> slot_free[wb_thread]);
endmodule

// File: rtl/ptr_lsu.sv
module ptr_lsu
  import lsu_pkg::*;
#(
  parameter int NT  = 4,
  parameter int NP  = 4,
  parameter int NB  = 4,
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int OW  = 12,
  parameter int RW  = 4,
  localparam int TW = $clog2(NT),
  localparam int PW = $clog2(NP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  output logic          op_ready,
  input  logic [TW-1:0] op_thread,
  input  logic          op_store,
  input  logic [PW-1:0] op_ptr,
  input  logic [OW-1:0] op_ofs,
  input  logic [DW-1:0] op_wdata,
  input  logic [RW-1:0] op_dest,
  input  logic          base_we,
  input  logic [TW-1:0] base_thread,
  input  logic [PW-1:0] base_ptr,
  input  logic [AW-1:0] base_addr,
  input  logic          inval,
  input  logic [TW-1:0] inval_thread,
  output logic          err_valid,
  output logic [TW-1:0] err_thread,
  output logic          bus_req_valid,
  input  logic          bus_req_ready,
  output logic [AW-1:0] bus_req_addr,
  output logic          bus_req_we,
  output logic [DW-1:0] bus_req_wdata,
  input  logic          bus_rsp_valid,
  input  logic [DW-1:0] bus_rsp_rdata,
  input  logic [NT-1:0] wb_slot_free,
  output logic          wb_valid,
  output logic [TW-1:0] wb_thread,
  output logic [RW-1:0] wb_reg,
  output logic [DW-1:0] wb_data
);
  logic [AW-1:0] base_rd, phys;
  logic          accept, misal, alloc, full;
  acc_kind_e     kind;

  lsu_base_regs #(.NT(NT), .NP(NP), .AW(AW)) u_base (
    .clk, .rst_n,
    .we(base_we), .wthread(base_thread), .wptr(base_ptr), .wdata(base_addr),
    .inval, .inval_thread,
    .rthread(op_thread), .rptr(op_ptr), .rdata(base_rd)
  );

  assign phys     = base_rd | AW'(op_ofs);
  assign misal    = phys[1:0] != 2'b00;
  assign op_ready = !full;
  assign accept   = op_valid && op_ready;
  assign alloc    = accept && !misal;
  assign kind     = op_store ? ACC_STORE : ACC_LOAD;

  lsu_txn_ring #(.NB(NB), .NT(NT), .AW(AW), .DW(DW), .RW(RW)) u_ring (
    .clk, .rst_n,
    .alloc, .alloc_kind(kind), .alloc_thread(op_thread), .alloc_reg(op_dest),
    .alloc_addr(phys), .alloc_wdata(op_wdata),
    .full,
    .req_valid(bus_req_valid), .req_ready(bus_req_ready),
    .req_addr(bus_req_addr), .req_we(bus_req_we), .req_wdata(bus_req_wdata),
    .rsp_valid(bus_rsp_valid), .rsp_rdata(bus_rsp_rdata),
    .slot_free(wb_slot_free),
    .wb_valid, .wb_thread, .wb_reg, .wb_data
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_valid  <= 1'b0;
      err_thread <= '0;
    end else begin
      err_valid  <= accept && misal;
      err_thread <= op_thread;
    end
  end

  // R5
  aligned_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> bus_req_addr[1:0] == 2'b00);
  // R5
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> $past(op_valid && op_ready));
endmodule

// File: tb/ptr_lsu_tb_top.sv
module ptr_lsu_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic op_valid, op_store, base_we, inval, bus_req_ready, bus_rsp_valid;
  logic [1:0] op_thread, op_ptr, base_thread, base_ptr, inval_thread;
  logic [11:0] op_ofs;
  logic [31:0] op_wdata, base_addr, bus_rsp_rdata;
  logic [3:0] op_dest, wb_slot_free;
  logic op_ready, err_valid, bus_req_valid, bus_req_we, wb_valid;
  logic [1:0] err_thread, wb_thread;
  logic [31:0] bus_req_addr, bus_req_wdata, wb_data;
  logic [3:0] wb_reg;

  always #2 clk = ~clk;

  ptr_lsu dut_i (.*);

  typedef struct {
    bit st; int thr; int dst; logic [31:0] addr; logic [31:0] data;
    bit issued; bit done;
  } ent_t;
  ent_t q[$];
  logic [31:0] mbase [4][4];
  bit m_err; int m_errt;
  int checks = 0, errors = 0, bus_pend = 0;
  bit op_hold = 0, exp_ready, exp_rv, finished = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic bit pct(input int p);
    return ($urandom % 100) < p;
  endfunction

  function automatic int first_unissued();
    foreach (q[i]) if (!q[i].issued) return i;
    return -1;
  endfunction

  task automatic drive(input int cyc);
    if (cyc < 10) begin
      base_we = 0; inval = 0; bus_rsp_valid = 0; wb_slot_free = '0;
      bus_req_ready = cyc >= 5;
      case (cyc)
        0: begin base_we = 1; base_thread = 1; base_ptr = 2; base_addr = 32'h8000_0000;
             op_valid = 1; op_store = 1; op_thread = 1; op_ptr = 2; op_ofs = 12'h124;
             op_wdata = 32'h0000_0011; op_dest = 0; end
        1: begin base_we = 1; base_thread = 1; base_ptr = 3; base_addr = 32'h4000_0000;
             inval = 1; inval_thread = 1;
             op_store = 0; op_ptr = 2; op_ofs = 12'h010; op_dest = 5; end
        2: begin op_ptr = 3; op_ofs = 12'h020; op_dest = 6; end
        3: begin op_ptr = 2; op_ofs = 12'h030; op_dest = 7; end
        4: begin op_store = 1; op_thread = 0; op_ptr = 0; op_ofs = 12'h002; end
        default: ;
      endcase
    end else begin
      int seg = (cyc - 10) / 400;
      if (!op_hold) begin
        op_valid = pct(20 + (seg * 29) % 75);
        op_store = pct(50); op_thread = 2'($urandom); op_ptr = 2'($urandom);
        op_ofs = pct(12) ? 12'($urandom) : {10'($urandom), 2'b00};
        op_wdata = $urandom; op_dest = 4'($urandom);
      end
      bus_req_ready = pct(15 + (seg * 41) % 80);
      bus_rsp_valid = (bus_pend > 0) && pct(20 + (seg * 53) % 75);
      bus_rsp_rdata = $urandom;
      for (int i = 0; i < 4; i++) wb_slot_free[i] = pct(10 + (seg * 67) % 85);
      base_we = pct(8); base_thread = 2'($urandom); base_ptr = 2'($urandom);
      base_addr = pct(10) ? $urandom : ($urandom & 32'hFFFF_F000);
      inval = pct(3); inval_thread = 2'($urandom);
    end
  endtask

  task automatic compare(input int cyc);
    int ii;
    bit ewb;
    exp_ready = q.size() < 4;
    chk("R6", "op_ready", op_ready, exp_ready);
    ii = first_unissued();
    exp_rv = ii >= 0;
    chk("R7", "bus_req_valid", bus_req_valid, exp_rv);
    if (exp_rv) begin
      chk("R2", "bus_req_addr", bus_req_addr, q[ii].addr);
      chk("R2", "bus_req_we", bus_req_we, q[ii].st);
      if (q[ii].st) chk("R10", "bus_req_wdata", bus_req_wdata, q[ii].data);
    end
    ewb = q.size() > 0 && q[0].done && !q[0].st && wb_slot_free[q[0].thr];
    chk("R9", "wb_valid", wb_valid, ewb);
    if (ewb) begin
      chk("R9", "wb_thread", wb_thread, q[0].thr);
      chk("R9", "wb_reg", wb_reg, q[0].dst);
      chk("R8", "wb_data", wb_data, q[0].data);
    end
    chk("R5", "err_valid", err_valid, m_err);
    if (m_err) chk("R5", "err_thread", err_thread, m_errt);
    case (cyc)
      0: chk("R7", "no request in accept cycle", bus_req_valid, 0);
      4: chk("R6", "ready low when full", op_ready, 0);
      5: chk("R3", "old base used on same-cycle write", bus_req_addr, 32'h0000_0124);
      6: chk("R3", "new base after write", bus_req_addr, 32'h8000_0010);
      7: chk("R4", "inval beats base write", bus_req_addr, 32'h0000_0020);
      8: chk("R4", "inval cleared base", bus_req_addr, 32'h0000_0030);
      default: ;
    endcase
  endtask

  task automatic update();
    int ii, ri;
    bit rel, mis;
    logic [31:0] phys;
    rel = q.size() > 0 && q[0].done && (q[0].st || wb_slot_free[q[0].thr]);
    ii = first_unissued();
    ri = -1;
    foreach (q[i]) if (ri < 0 && q[i].issued && !q[i].done) ri = i;
    if (bus_rsp_valid && ri >= 0) begin
      q[ri].done = 1;
      if (!q[ri].st) q[ri].data = bus_rsp_rdata;
    end
    if (ii >= 0 && bus_req_ready) q[ii].issued = 1;
    if (rel) void'(q.pop_front());
    phys = mbase[op_thread][op_ptr] | {20'h0, op_ofs};
    mis = phys[1:0] != 2'b00;
    m_err = op_valid && exp_ready && mis;
    m_errt = op_thread;
    if (op_valid && exp_ready && !mis) begin
      ent_t e;
      e.st = op_store; e.thr = op_thread; e.dst = op_dest; e.addr = phys;
      e.data = op_wdata; e.issued = 0; e.done = 0;
      q.push_back(e);
    end
    op_hold = op_valid && !exp_ready;
    bus_pend += ((exp_rv && bus_req_ready) ? 1 : 0) - (bus_rsp_valid ? 1 : 0);
    if (inval) for (int p = 0; p < 4; p++) mbase[inval_thread][p] = '0;
    if (base_we && !(inval && inval_thread == base_thread))
      mbase[base_thread][base_ptr] = base_addr;
  endtask

  initial begin
    #800000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; op_valid = 0; op_store = 0; op_thread = 0; op_ptr = 0; op_ofs = 0;
    op_wdata = 0; op_dest = 0; base_we = 0; base_thread = 0; base_ptr = 0;
    base_addr = 0; inval = 0; inval_thread = 0; bus_req_ready = 0;
    bus_rsp_valid = 0; bus_rsp_rdata = 0; wb_slot_free = 0; m_err = 0; m_errt = 0;
    for (int t = 0; t < 4; t++) for (int p = 0; p < 4; p++) mbase[t][p] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "op_ready", op_ready, 1);
    chk("R1", "bus_req_valid", bus_req_valid, 0);
    chk("R1", "wb_valid", wb_valid, 0);
    chk("R1", "err_valid", err_valid, 0);
    rst_n = 1;
    for (int cyc = 0; cyc < 3210; cyc++) begin
      @(negedge clk);
      drive(cyc);
      #1;
      compare(cyc);
      @(posedge clk);
      update();
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule